// File: doc/BRIEF.md
# Prescaled Sixteen-Bit Timer Counter with Byte-Coherent Readout

This block is the counting core of a timer. It picks one of three count sources, or none. The sources are the bus clock itself, a periodic tick supplied by the chip, and an external pin that is synchronized inside the block. The chosen source then passes through a power-of-two prescaler. Each prescaler output advances a sixteen-bit counter. The counter either climbs to a programmable modulus and wraps, or sweeps up and down between zero and the modulus, as a center-aligned PWM stage needs.

Software sees the count only one byte at a time over an eight-bit read port. Whichever byte is read first freezes a snapshot of the whole count. The other byte then comes from that snapshot, so a sixteen-bit value is always assembled from one instant in either byte order. A write strobe restarts the counter and the prescaler and drops any pending snapshot. A sticky overflow flag and a direction output go to the channel logic that sits beside this block.

Top module: `prescaled_timer`

## Requirements
- R1: After synchronous reset the count is zero, `ovf_flag` is 0, `count_down` is 0 and `rd_data` is 0x00.
- R2: With `clk_sel` = 2'b00 the counter holds its value no matter how many cycles pass.
- R3: With `clk_sel` = 2'b01 every bus cycle is a source tick. With `clk_sel` = 2'b10 only cycles with `fixed_tick` high are source ticks.
- R4: With `clk_sel` = 2'b11, each rising edge of `ext_clk` is one source tick, taken through a two-flop synchronizer. An edge is counted at most four cycles after the pin rises.
- R5: The prescaler passes one counter step per 2^`pscale` source ticks (`pscale` 0..7 gives 1..128). It starts from zero after reset or a count write.
- R6: A new `pscale` value governs the prescaler from the first clock edge after it is applied, without stopping the count.
- R7: With `mode_updown` = 0, a step taken at the terminal value (`modulus`, or 0xFFFF when `modulus` = 0) sets the count to 0x0000 and sets `ovf_flag`. Any other step adds one.
- R8: With `mode_updown` = 1, the count rises to the terminal value and then falls. The step taken at the terminal value gives terminal−1, sets `ovf_flag` and sets `count_down` to 1. The step taken at zero while falling gives 1 and clears `count_down`. Whenever `mode_updown` is 0, `count_down` reads 0 from the next cycle on.
- R9: A read strobe (`rd_en` = 1) returns a byte on `rd_data` in the next cycle: bits 15:8 when `rd_hi` = 1, bits 7:0 when `rd_hi` = 0. `rd_data` holds between reads.
- R10: The first byte read with no snapshot pending returns the live value and captures the full count. Every later read returns bytes from that capture. The first read of the other byte releases the capture.
- R11: A pulse on `cnt_wr` sets the count to zero, clears `count_down`, restarts the prescaler and releases any pending capture.
- R12: `ovf_flag` stays set until a cycle with `ovf_clr` = 1. If a new overflow occurs in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_updown | input | 1 | 0 = count up and wrap, 1 = up/down sweep |
| clk_sel | input | 2 | Count source: 00 off, 01 bus, 10 fixed tick, 11 external pin |
| pscale | input | 3 | Prescale exponent, divide by 2^pscale |
| fixed_tick | input | 1 | Periodic tick enable from the chip |
| ext_clk | input | 1 | Asynchronous external count input |
| modulus | input | 16 | Terminal count value, 0 selects full range |
| cnt_wr | input | 1 | Count write strobe, restarts counter |
| rd_en | input | 1 | Byte read strobe |
| rd_hi | input | 1 | Byte select for the read, 1 = upper byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_data | output | 8 | Registered read byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| count_down | output | 1 | 1 while the sweep is falling |

## Verification
The counting path is driven by steady bus ticks at several prescale settings, by a sparse pattern on the fixed tick, and by slow pulses on the external pin. This shows whether each source feeds exactly one tick per event and whether the divider truncates correctly. Short and full-range moduli in both modes separate a correct wrap or turn from an off-by-one at the terminal value or at zero. Reads are made in low-then-high and high-then-low order while the counter runs between the two reads. A stale byte therefore differs from the live one, which shows whether the snapshot was taken, used and released. A write placed between the two reads does the same for the release on write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_BUS   = 2'b01,
    SRC_FIXED = 2'b10,
    SRC_EXT   = 2'b11
  } src_sel_e;

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       fixed_tick,
  input  logic       ext_in,
  output logic       src_en
);
  import tmr_pkg::*;

  // sync chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] sh_q;
  logic                 ext_edge;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], ext_in};
  end

  assign ext_edge = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  always_comb begin
    unique case (src_sel_e'(sel))
      SRC_BUS:   src_en = 1'b1;
      SRC_FIXED: src_en = fixed_tick;
      SRC_EXT:   src_en = ext_edge;
      default:   src_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            src_en,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // mask = 2^ps - 1, taken from the live setting every cycle
  assign mask = ~({DIV_W{1'b1}} << ps);
  assign tick = src_en & (div_q >= mask);

  always_ff @(posedge clk) begin
    if (rst || clr)  div_q <= '0;
    else if (src_en) div_q <= tick ? '0 : div_q + 1'b1;
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             updown,
  input  logic [CNT_W-1:0] modulus,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             ovf
);
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] cnt_n;
  logic             dir_n;
  logic             wrap;

  assign top = (modulus == '0) ? {CNT_W{1'b1}} : modulus;

  always_comb begin
    cnt_n = cnt;
    dir_n = updown ? dir_down : 1'b0;
    wrap  = 1'b0;
    if (clr) begin
      cnt_n = '0;
      dir_n = 1'b0;
    end else if (tick) begin
      if (!updown) begin
        if (cnt >= top) begin
          cnt_n = '0;
          wrap  = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end else if (!dir_down) begin
        if (cnt >= top) begin
          cnt_n = cnt - 1'b1;
          dir_n = 1'b1;
          wrap  = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end else begin
        if (cnt == '0) begin
          cnt_n = {{(CNT_W-1){1'b0}}, 1'b1};
          dir_n = 1'b0;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dir_down <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      cnt      <= cnt_n;
      dir_down <= dir_n;
      if (wrap)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_read_latch.sv
module tmr_read_latch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rd_en,
  input  logic              rd_hi,
  input  logic [2*BYTE_W-1:0] cnt,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] snap_q;
  logic              held_q;
  logic              first_hi_q;
  logic [WORD_W-1:0] src;

  assign src = held_q ? snap_q : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q     <= '0;
      held_q     <= 1'b0;
      first_hi_q <= 1'b0;
      rd_data    <= '0;
    end else begin
      if (rd_en) rd_data <= rd_hi ? src[WORD_W-1:BYTE_W] : src[BYTE_W-1:0];
      if (clr) begin
        held_q <= 1'b0;
      end else if (rd_en) begin
        if (!held_q) begin
          held_q     <= 1'b1;
          snap_q     <= cnt;
          first_hi_q <= rd_hi;
        end else if (rd_hi != first_hi_q) begin
          held_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int BYTE_W      = 8,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_updown,
  input  logic [1:0]        clk_sel,
  input  logic [PS_W-1:0]   pscale,
  input  logic              fixed_tick,
  input  logic              ext_clk,
  input  logic [CNT_W-1:0]  modulus,
  input  logic              cnt_wr,
  input  logic              rd_en,
  input  logic              rd_hi,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ovf_flag,
  output logic              count_down
);
  logic             src_en;
  logic             step;
  logic [CNT_W-1:0] cnt_q;

  tmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk        (clk),
    .rst        (rst),
    .sel        (clk_sel),
    .fixed_tick (fixed_tick),
    .ext_in     (ext_clk),
    .src_en     (src_en)
  );

  tmr_prescaler #(.PS_W(PS_W)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .clr    (cnt_wr),
    .src_en (src_en),
    .ps     (pscale),
    .tick   (step)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_wr),
    .tick     (step),
    .updown   (mode_updown),
    .modulus  (modulus),
    .ovf_clr  (ovf_clr),
    .cnt      (cnt_q),
    .dir_down (count_down),
    .ovf      (ovf_flag)
  );

  tmr_read_latch #(.BYTE_W(BYTE_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_wr),
    .rd_en   (rd_en),
    .rd_hi   (rd_hi),
    .cnt     (cnt_q),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_updown,
  input logic [1:0]       clk_sel,
  input logic [2:0]       pscale,
  input logic [CNT_W-1:0] modulus,
  input logic             cnt_wr,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf_flag,
  input logic             count_down
);

  p_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 2'b00 && !cnt_wr) |=> $stable(cnt));

  p_bus_step_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 2'b01 && pscale == 3'd0 && !cnt_wr && !mode_updown && modulus == '0)
    |=> cnt == $past(cnt) + CNT_W'(1));

  p_up_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (!mode_updown && modulus != '0 && cnt <= modulus) |=> cnt <= $past(modulus));

  p_no_down_r8: assert property (@(posedge clk) disable iff (rst)
    !mode_updown |=> !count_down);

  p_wr_clear_r11: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == '0 && !count_down));

  p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_updown (mode_updown),
  .clk_sel     (clk_sel),
  .pscale      (pscale),
  .modulus     (modulus),
  .cnt_wr      (cnt_wr),
  .ovf_clr     (ovf_clr),
  .cnt         (cnt_q),
  .ovf_flag    (ovf_flag),
  .count_down  (count_down)
);

// File: tb/prescaled_timer_tb_top.sv
module prescaled_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_updown = 1'b0;
  logic [1:0]  clk_sel = 2'b00;
  logic [2:0]  pscale = 3'd0;
  logic        fixed_tick = 1'b0;
  logic        ext_clk = 1'b0;
  logic [15:0] modulus = 16'h0000;
  logic        cnt_wr = 1'b0;
  logic        rd_en = 1'b0;
  logic        rd_hi = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [7:0]  rd_data;
  logic        ovf_flag;
  logic        count_down;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  prescaled_timer dut_i (
    .clk(clk), .rst(rst), .mode_updown(mode_updown), .clk_sel(clk_sel),
    .pscale(pscale), .fixed_tick(fixed_tick), .ext_clk(ext_clk),
    .modulus(modulus), .cnt_wr(cnt_wr), .rd_en(rd_en), .rd_hi(rd_hi),
    .ovf_clr(ovf_clr), .rd_data(rd_data), .ovf_flag(ovf_flag),
    .count_down(count_down)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_bus(input int n);
    clk_sel = 2'b01;
    wait_n(n);
    clk_sel = 2'b00;
  endtask

  task automatic do_write();
    cnt_wr = 1'b1;
    wait_n(1);
    cnt_wr = 1'b0;
  endtask

  task automatic do_clr_ovf();
    ovf_clr = 1'b1;
    wait_n(1);
    ovf_clr = 1'b0;
  endtask

  task automatic rd_byte(input logic hi, output logic [7:0] b);
    rd_en = 1'b1;
    rd_hi = hi;
    wait_n(1);
    rd_en = 1'b0;
    b = rd_data;
  endtask

  task automatic rd_count(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_byte(1'b0, lo);
    rd_byte(1'b1, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 rd_data", rd_data, 0);
    check("R1 ovf", ovf_flag, 0);
    check("R1 dir", count_down, 0);
    rd_count(v);
    check("R1 count", v, 0);
  endtask

  task automatic t_bus_stop();
    logic [15:0] v;
    pscale = 0; do_write();
    run_bus(7);
    wait_n(20);
    rd_count(v);
    check("R3 bus 7 ticks / R2 hold", v, 7);
    wait_n(15);
    rd_count(v);
    check("R2 stopped", v, 7);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    for (int k = 0; k < 8; k++) begin
      pscale = 3'(k);
      do_write();
      run_bus(256);
      rd_count(v);
      check($sformatf("R5 ps=%0d", k), v, 256 >> k);
    end
    pscale = 3; do_write();
    run_bus(15);
    rd_count(v);
    check("R5 partial ps=3", v, 1);
    pscale = 0;
  endtask

  task automatic t_ps_switch();
    logic [15:0] v;
    pscale = 0; do_write();
    clk_sel = 2'b01;
    wait_n(10);
    pscale = 1;
    wait_n(10);
    clk_sel = 2'b00;
    rd_count(v);
    check("R6 live prescale change", v, 15);
    pscale = 0;
  endtask

  task automatic t_fixed();
    logic [15:0] v;
    pscale = 0; do_write();
    clk_sel = 2'b10;
    for (int i = 0; i < 30; i++) begin
      fixed_tick = (i % 3 == 0);
      wait_n(1);
    end
    fixed_tick = 1'b0;
    wait_n(20);
    clk_sel = 2'b00;
    rd_count(v);
    check("R3 fixed tick", v, 10);
  endtask

  task automatic t_ext();
    logic [15:0] v;
    ext_clk = 1'b0; pscale = 0;
    do_write();
    clk_sel = 2'b11;
    for (int i = 0; i < 6; i++) begin
      ext_clk = 1'b1; wait_n(2);
      ext_clk = 1'b0; wait_n(2);
    end
    wait_n(4);
    clk_sel = 2'b00;
    rd_count(v);
    check("R4 ext edges", v, 6);
  endtask

  task automatic t_up_wrap();
    logic [15:0] v;
    mode_updown = 0; modulus = 16'd5; pscale = 0;
    do_write(); do_clr_ovf();
    run_bus(5);
    rd_count(v);
    check("R7 at modulus", v, 5);
    check("R7 no ovf yet", ovf_flag, 0);
    run_bus(1);
    rd_count(v);
    check("R7 wrap to 0", v, 0);
    check("R7 ovf set", ovf_flag, 1);
    modulus = 16'd0;
    do_write(); do_clr_ovf();
    run_bus(65535);
    rd_count(v);
    check("R7 full range top", v, 16'hFFFF);
    check("R7 full range no ovf", ovf_flag, 0);
    run_bus(1);
    rd_count(v);
    check("R7 full range wrap", v, 0);
    check("R7 full range ovf", ovf_flag, 1);
  endtask

  task automatic t_updown();
    logic [15:0] v;
    mode_updown = 1; modulus = 16'd5; pscale = 0;
    do_write(); do_clr_ovf();
    run_bus(5);
    rd_count(v);
    check("R8 rise to top", v, 5);
    check("R8 dir up", count_down, 0);
    check("R8 no ovf", ovf_flag, 0);
    run_bus(1);
    rd_count(v);
    check("R8 turn at top", v, 4);
    check("R8 dir down", count_down, 1);
    check("R8 ovf at top", ovf_flag, 1);
    do_clr_ovf();
    run_bus(5);
    rd_count(v);
    check("R8 turn at zero", v, 1);
    check("R8 dir up again", count_down, 0);
    check("R8 no ovf at zero", ovf_flag, 0);
    run_bus(5);
    check("R8 down again", count_down, 1);
    mode_updown = 0;
    wait_n(1);
    check("R8 mode clear drops dir", count_down, 0);
    modulus = 16'd0;
  endtask

  task automatic t_coherent();
    logic [7:0] b;
    mode_updown = 0; modulus = 0; pscale = 0;
    do_write();
    run_bus(300);
    rd_byte(1'b0, b);
    check("R10 lo first live", b, 8'h2C);
    run_bus(300);
    rd_byte(1'b1, b);
    check("R10 hi from capture", b, 8'h01);
    rd_byte(1'b1, b);
    check("R10 released, hi live", b, 8'h02);
    run_bus(100);
    rd_byte(1'b1, b);
    check("R10 repeat hi from capture", b, 8'h02);
    rd_byte(1'b0, b);
    check("R10 lo from capture", b, 8'h58);
    rd_byte(1'b0, b);
    check("R9 lo byte", b, 8'hBC);
    rd_byte(1'b1, b);
    check("R9 hi byte", b, 8'h02);
    wait_n(5);
    check("R9 rd_data holds", rd_data, 8'h02);
  endtask

  task automatic t_write();
    logic [7:0]  b;
    logic [15:0] v;
    pscale = 0; do_write();
    run_bus(300);
    rd_byte(1'b0, b);
    do_write();
    run_bus(768);
    rd_byte(1'b1, b);
    check("R11 write drops capture", b, 8'h03);
    rd_byte(1'b0, b);
    check("R11 count restarted", b, 8'h00);
    pscale = 2; do_write();
    run_bus(3);
    do_write();
    run_bus(1);
    rd_count(v);
    check("R11 prescaler restart", v, 0);
    run_bus(3);
    rd_count(v);
    check("R11 prescaler full period", v, 1);
    pscale = 0;
  endtask

  task automatic t_ovf();
    mode_updown = 0; modulus = 16'd2; pscale = 0;
    do_write(); do_clr_ovf();
    run_bus(3);
    check("R12 ovf set", ovf_flag, 1);
    run_bus(20);
    check("R12 ovf sticky", ovf_flag, 1);
    do_clr_ovf();
    check("R12 ovf cleared", ovf_flag, 0);
    modulus = 16'd0;
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_bus_stop();
    t_prescale();
    t_ps_switch();
    t_fixed();
    t_ext();
    t_up_wrap();
    t_updown();
    t_coherent();
    t_write();
    t_ovf();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule